// File: doc/BRIEF.md
# Note Length Counter

This unit holds the remaining duration of one audio channel's note. On a load it takes its start value from a fixed 32-entry table, addressed by a 5-bit index. It then counts down by one on each half-frame tick until it reaches zero. A halt flag freezes the count. A channel enable, taken from the status register, clears the count and blocks loads while it is low. The count and a nonzero flag are the outputs. The status logic reads the nonzero flag to decide whether the channel still sounds.

The unit fixes the order of events within one clock. A halt write takes effect after any decrement in the same cycle, so the old halt value governs that decrement. A load that arrives together with a half-frame tick is dropped while the count is nonzero. The same load goes through when the count is zero. Every state change is registered on the rising clock edge.

Top module: `note_len_counter`

## Requirements
- R1: After reset the count is 0 and `active` is low.
- R2: With `chan_en` high, `load_stb` sets the count one clock later to the table entry for `load_idx`, unless R8 applies. For an odd index i the entry is 254 when i is 1 and i-1 otherwise. For an even index, k is bits 3:1 and h is bit 4. For k from 0 to 4 the entry is (h ? 12 : 10) shifted left by k. For k = 5, 6 and 7 the entries are 60, 14 and 26 when h is 0, and 72, 16 and 32 when h is 1.
- R3: While `chan_en` is low, the count is 0 one clock later.
- R4: A `load_stb` while `chan_en` is low has no effect: the count remains 0.
- R5: A `half_tick` with the count nonzero and the halt flag clear lowers the count by one on the next clock.
- R6: While the halt flag is set, a `half_tick` leaves the count unchanged.
- R7: `halt_wr` stores `halt_val` into the halt flag. The flag is used only from the following cycle on. A `half_tick` in the same cycle as the write is governed by the previous flag value.
- R8: A `load_stb` in the same cycle as a `half_tick` is ignored while the count is nonzero. The decrement rule applies instead.
- R9: A `load_stb` in the same cycle as a `half_tick` loads normally while the count is 0.
- R10: A load one cycle before or one cycle after a `half_tick` loads normally.
- R11: At zero the count does not wrap. A `half_tick` leaves it at 0.
- R12: `active` is high exactly when the count is greater than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable level from the status register |
| halt_wr | input | 1 | Strobe that writes the halt flag |
| halt_val | input | 1 | New halt flag value |
| load_stb | input | 1 | Load strobe |
| load_idx | input | 5 | Length table index |
| half_tick | input | 1 | Half-frame clock pulse |
| count | output | 8 | Current length count |
| active | output | 1 | High when the count is nonzero |

## Verification
Loads, decrements and clears all change `count` exactly one clock after the edge that samples the stimulus. `active` follows `count` in the same cycle. A halt write changes no output by itself; it alters only how the next `half_tick` is handled. The bench drives each stimulus at a falling edge and lets one rising edge pass. At the next falling edge it compares both outputs with a model that applies the rules in order. Each collision case (tick with load, tick with halt write) is therefore checked in the single cycle where the order matters.

// File: rtl/note_len_pkg.sv
package note_len_pkg;
  localparam int IDX_W = 5;
  localparam int CNT_W = 8;
  localparam int TBL_DEPTH = 1 << IDX_W;

  // Length table entry for a 5-bit index.
  function automatic logic [CNT_W-1:0] len_lookup(input logic [IDX_W-1:0] idx);
    logic [CNT_W-1:0] v;
    if (idx[0]) begin
      v = (idx == 5'd1) ? 8'd254 : {3'b000, idx} - 8'd1;
    end else if (!idx[4]) begin
      case (idx[3:1])
        3'd0: v = 8'd10;   3'd1: v = 8'd20;
        3'd2: v = 8'd40;   3'd3: v = 8'd80;
        3'd4: v = 8'd160;  3'd5: v = 8'd60;
        3'd6: v = 8'd14;   default: v = 8'd26;
      endcase
    end else begin
      case (idx[3:1])
        3'd0: v = 8'd12;   3'd1: v = 8'd24;
        3'd2: v = 8'd48;   3'd3: v = 8'd96;
        3'd4: v = 8'd192;  3'd5: v = 8'd72;
        3'd6: v = 8'd16;   default: v = 8'd32;
      endcase
    end
    return v;
  endfunction

  // Saturating decrement.
  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/note_len_halt.sv
module note_len_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_wr,
  input  logic halt_val,
  output logic halt_q
);
  // The stored flag reaches the counter only from the next cycle on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt_q <= 1'b0;
    else if (halt_wr) halt_q <= halt_val;
  end
endmodule

// File: rtl/note_len_table.sv
module note_len_table
  import note_len_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int CW = CNT_W
) (
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] value
);
  always_comb value = CW'(len_lookup(IDX_W'(idx)));
endmodule

// File: rtl/note_len_core.sv
module note_len_core
  import note_len_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          half_tick,
  input  logic          halt_q,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          dec_evt,
  output logic          load_evt,
  output logic          drop_evt
);
  logic nz;
  logic tick_owns;

  assign nz        = (count != '0);
  // A tick on a nonzero count has priority over a load in the same cycle.
  assign tick_owns = chan_en & half_tick & nz;
  assign dec_evt   = tick_owns & ~halt_q;
  assign drop_evt  = tick_owns & load_stb;
  assign load_evt  = chan_en & load_stb & ~tick_owns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (!chan_en) count <= '0;
    else if (dec_evt)  count <= CW'(dec_sat(CNT_W'(count)));
    else if (load_evt) count <= load_val;
  end
endmodule

// File: rtl/note_len_counter.sv
module note_len_counter
  import note_len_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          halt_wr,
  input  logic          halt_val,
  input  logic          load_stb,
  input  logic [IW-1:0] load_idx,
  input  logic          half_tick,
  output logic [CW-1:0] count,
  output logic          active
);
  logic          halt_q;
  logic [CW-1:0] load_val;
  logic          dec_evt;
  logic          load_evt;
  logic          drop_evt;

  note_len_halt i_halt (
    .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr),
    .halt_val(halt_val), .halt_q(halt_q)
  );

  note_len_table #(.IW(IW), .CW(CW)) i_table (
    .idx(load_idx), .value(load_val)
  );

  note_len_core #(.CW(CW)) i_core (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .half_tick(half_tick),
    .halt_q(halt_q), .load_stb(load_stb), .load_val(load_val),
    .count(count), .dec_evt(dec_evt), .load_evt(load_evt),
    .drop_evt(drop_evt)
  );

  assign active = (count != '0);
endmodule

// File: rtl/note_len_chk.sv
module note_len_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          half_tick,
  input logic          load_stb,
  input logic          halt_q,
  input logic          drop_evt,
  input logic [CW-1:0] count,
  input logic          active
);
  // R3
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (count == '0));

  // R6
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && half_tick && halt_q && count != '0) |=> (count == $past(count)));

  // R8
  collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && half_tick && load_stb && !halt_q && count != '0)
      |=> (count == $past(count) - 1'b1));

  // R8
  drop_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && halt_q) |=> $stable(count));

  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_stb) |=> (count == '0));

  // R12
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(load_stb && chan_en));
endmodule

bind note_len_counter note_len_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .half_tick(half_tick),
  .load_stb(load_stb), .halt_q(halt_q), .drop_evt(drop_evt),
  .count(count), .active(active)
);

// File: tb/test_note_len_counter.sv
`timescale 1ns/1ps
module test_note_len_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_en = 1'b0, halt_wr = 1'b0, halt_val = 1'b0;
  logic       load_stb = 1'b0, half_tick = 1'b0;
  logic [4:0] load_idx = '0;
  logic [7:0] count;
  logic       active;

  int vectors = 0;
  int errors  = 0;
  int m_cnt   = 0;
  bit m_halt  = 1'b0;

  always #5 clk = ~clk;

  note_len_counter i_note_len_counter (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .halt_wr(halt_wr),
    .halt_val(halt_val), .load_stb(load_stb), .load_idx(load_idx),
    .half_tick(half_tick), .count(count), .active(active)
  );

  // Table restated arithmetically (R2).
  function automatic int tbl(int i);
    int k, h;
    if (i % 2 == 1) return (i == 1) ? 254 : i - 1;
    k = (i / 2) % 8;
    h = i / 16;
    if (k < 5) return (h ? 12 : 10) * (1 << k);
    if (k == 5) return h ? 72 : 60;
    if (k == 6) return h ? 16 : 14;
    return h ? 32 : 26;
  endfunction

  task automatic check(string req);
    vectors++;
    if (count !== 8'(m_cnt) || active !== (m_cnt > 0)) begin
      errors++;
      $display("FAIL %s: count=%0d active=%0b expected count=%0d active=%0b",
               req, count, active, m_cnt, (m_cnt > 0));
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(bit en, bit hw, bit hv, bit ld, int idx, bit tk, string req);
    chan_en = en; halt_wr = hw; halt_val = hv;
    load_stb = ld; load_idx = 5'(idx); half_tick = tk;
    @(posedge clk);
    if (!en)                        m_cnt = 0;
    else if (tk && m_cnt > 0)       m_cnt = m_halt ? m_cnt : m_cnt - 1;
    else if (ld)                    m_cnt = tbl(idx);
    if (hw) m_halt = hv;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // Sweep every index: load, tick, blocked load while disabled.
    for (int i = 0; i < 32; i++) begin
      cyc(1, 0, 0, 1, i, 0, "R2");
      cyc(1, 0, 0, 0, 0, 1, "R5");
      cyc(0, 0, 0, 0, 0, 0, "R3");
      cyc(0, 0, 0, 1, i, 0, "R4");
      cyc(0, 0, 0, 1, i, 1, "R4");
    end

    // R11: run a count of 2 down past zero.
    cyc(1, 0, 0, 1, 3, 0, "R2");
    cyc(1, 0, 0, 0, 0, 1, "R5");
    cyc(1, 0, 0, 0, 0, 1, "R5");
    cyc(1, 0, 0, 0, 0, 1, "R11");
    cyc(1, 0, 0, 0, 0, 1, "R11");

    // R6: halted count holds.
    cyc(1, 0, 0, 1, 0, 0, "R2");
    cyc(1, 1, 1, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 1, "R6");
    // R7: release in tick cycle, old (halted) value governs.
    cyc(1, 1, 0, 0, 0, 1, "R7");
    cyc(1, 0, 0, 0, 0, 1, "R7");
    // R7: set halt in tick cycle, decrement still happens.
    cyc(1, 1, 1, 0, 0, 1, "R7");
    cyc(1, 0, 0, 0, 0, 1, "R7");
    cyc(1, 1, 0, 0, 0, 0, "R7");

    // R8: load with tick on nonzero count is dropped.
    cyc(1, 0, 0, 1, 2, 1, "R8");
    cyc(1, 0, 0, 1, 9, 1, "R8");
    // R9: count to zero, then load with tick.
    cyc(0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 8, 1, "R9");
    // R10: load just before and just after a tick.
    cyc(1, 0, 0, 1, 31, 0, "R10");
    cyc(1, 0, 0, 0, 0, 1, "R10");
    cyc(1, 0, 0, 1, 17, 0, "R10");
    cyc(1, 0, 0, 0, 0, 0, "R12");

    // Mixed pseudo-random traffic against the model.
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[7:0] != 8'h00, lfsr[3] & lfsr[9], lfsr[5],
          lfsr[2] & lfsr[4] & lfsr[11], int'(lfsr[15:11]),
          lfsr[1] | lfsr[6], "R8 R12 mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule